// File: doc/BRIEF.md
# Flash thermometer-to-Gray encoder

This block is the digital back end of a 6-bit flash analogue-to-digital converter. It receives the 63 already-registered comparator decisions as a thermometer code, with comparator bit k-1 standing for reference level k. It also receives one flag per comparator that marks that comparator's decision as undecided. Each slice compares three neighbouring levels to select one word line. Isolated spurious ones above the transition therefore never reach the encoding stage. A wired-OR table then maps the selected lines onto a Gray code.

The Gray result is registered and also passed through a registered Gray-to-binary stage, so both codes are available. Each clock cycle accepts a new sample. The Gray output follows the input after one cycle and the binary output after two. Undecided comparators are forced to logic one before the slice logic. An unresolved decision therefore shifts the result by at most one code and cannot leave every word line idle.

Top module: `thermo_gray_enc`

## Requirements
- R1: While `rst_n` is low, `gray_o` and `bin_o` are both 0 whatever the comparator inputs are.
- R2: For a clean thermometer input (comparator bits 0..k-1 high, all others low, no undecided flag), `gray_o` equals k XOR (k >> 1) one clock after the sample is taken.
- R3: `bin_o` is the plain binary value of the `gray_o` code of the previous cycle, so it carries level k two clocks after a clean sample with k ones.
- R4: A single high comparator bit j whose neighbours j-1 and j+1 are low, lying at least two positions above the top of the ones run, has no effect: the output equals the code of the clean run alone.
- R5: A high undecided flag on comparator bit j makes that bit count as high. Just above the transition this gives level k+1, and far above it the bit acts as an isolated one and is ignored. With every flag high and every comparator low, the result is level 63 (Gray 32).
- R6: When several word lines are selected (a low bit inside the ones run), `gray_o` is the bitwise OR of the Gray codes of all selected lines. Line i is selected when levels i-1 and i are high and level i+1 is low, with level 0 taken as high and level 64 as low.
- R7: The block accepts one new sample every cycle. Samples presented on consecutive cycles appear on `gray_o` on consecutive cycles, in order.
- R8: All comparators low gives code 0, and all comparators high gives level 63 (Gray 32, binary 63).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_i | input | 63 | Registered comparator decisions; bit k-1 is reference level k |
| undec_i | input | 63 | Per-comparator flag marking an unresolved decision |
| gray_o | output | 6 | Gray-coded level, one cycle after the sample |
| bin_o | output | 6 | Binary level, two cycles after the sample |

## Verification
The clean runs at levels 0, 1, 5, 32, 42 and 63 confirm the table contents and the ends of the range. They are told apart from each other because their Gray codes differ in several bit positions. Inputs with an isolated one far above the run show whether the three-input select actually rejects bubbles, compared with a two-input edge detector that would add a second line. Undecided flags placed just above, far above and over the whole range show the force-to-one rule and its bounded error. Inputs with a low bit inside the ones run select two lines, which exposes the wired-OR merge. A back-to-back stream separates a true one-sample-per-cycle pipeline from one that stalls or reorders.

// File: rtl/ttg_pkg.sv
package ttg_pkg;

    // Gray code of a level index
    function automatic int gray_of(input int lvl);
        return lvl ^ (lvl >> 1);
    endfunction

    // Binary value of a Gray code, by prefix XOR from the top bit down
    function automatic int bin_of(input int g, input int width);
        int b;
        b = 0;
        for (int i = width - 1; i >= 0; i--) begin
            b[i] = g[i] ^ ((i == width - 1) ? 1'b0 : b[i + 1]);
        end
        return b;
    endfunction

endpackage

// File: rtl/ttg_wordline.sv
module ttg_wordline #(
    parameter int NCMP = 63
) (
    input  logic [NCMP-1:0] cmp,
    input  logic [NCMP-1:0] undec,
    output logic [NCMP:0]   sel
);
    // Level vector: index 0 always high, index NCMP+1 always low
    logic [NCMP+1:0] lvl;

    assign lvl[0]      = 1'b1;
    assign lvl[NCMP+1] = 1'b0;

    genvar k;
    generate
        for (k = 1; k <= NCMP; k++) begin : g_force
            // undecided comparators resolve to one
            assign lvl[k] = cmp[k-1] | undec[k-1];
        end
        for (k = 0; k <= NCMP; k++) begin : g_slice
            if (k == 0) begin : g_bottom
                assign sel[k] = ~lvl[1];
            end else begin : g_mid
                assign sel[k] = lvl[k-1] & lvl[k] & ~lvl[k+1];
            end
        end
    endgenerate

    // A thermometer-shaped level vector must select exactly one line
    always_comb begin
        if (!$isunknown(lvl) && ((~lvl[NCMP:0] & lvl[NCMP+1:1]) == '0)) begin
            assert_clean_onehot_R2: assert ($onehot(sel))
                else $error("clean thermometer selected %0d lines", $countones(sel));
        end
    end

endmodule

// File: rtl/ttg_or_rom.sv
module ttg_or_rom #(
    parameter int OUT_W = 6,
    parameter int NLINE = 64
) (
    input  logic [NLINE-1:0] sel,
    output logic [OUT_W-1:0] code
);
    logic [OUT_W-1:0] acc;

    // Wired-OR: every selected line pulls its own Gray pattern onto the bus
    always_comb begin
        acc = '0;
        for (int i = 0; i < NLINE; i++) begin
            if (sel[i]) acc = acc | OUT_W'(ttg_pkg::gray_of(i));
        end
        // pull-up leaves all ones when nothing drives the bus
        code = (sel == '0) ? '1 : acc;
    end

    // Forcing undecided inputs high keeps at least one line driven
    always_comb begin
        if (!$isunknown(sel)) begin
            assert_line_driven_R5: assert (sel != '0)
                else $error("no word line selected");
        end
    end

endmodule

// File: rtl/ttg_gray2bin.sv
module ttg_gray2bin #(
    parameter int OUT_W = 6
) (
    input  logic [OUT_W-1:0] gray,
    output logic [OUT_W-1:0] bin
);
    genvar i;
    generate
        for (i = 0; i < OUT_W; i++) begin : g_bit
            assign bin[i] = ^gray[OUT_W-1:i];
        end
    endgenerate
endmodule

// File: rtl/thermo_gray_enc.sv
module thermo_gray_enc #(
    parameter int OUT_W = 6,
    localparam int NCMP = (1 << OUT_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCMP-1:0]  cmp_i,
    input  logic [NCMP-1:0]  undec_i,
    output logic [OUT_W-1:0] gray_o,
    output logic [OUT_W-1:0] bin_o
);
    typedef struct packed {
        logic [OUT_W-1:0] gray;
        logic [OUT_W-1:0] bin;
    } stage_t;

    stage_t st_d, st_q;

    logic [NCMP:0]    sel_w;
    logic [OUT_W-1:0] rom_w;
    logic [OUT_W-1:0] bin_w;

    ttg_wordline #(.NCMP(NCMP)) u_wl (
        .cmp   (cmp_i),
        .undec (undec_i),
        .sel   (sel_w)
    );

    ttg_or_rom #(.OUT_W(OUT_W), .NLINE(NCMP + 1)) u_rom (
        .sel  (sel_w),
        .code (rom_w)
    );

    ttg_gray2bin #(.OUT_W(OUT_W)) u_g2b (
        .gray (st_q.gray),
        .bin  (bin_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.gray = rom_w;
        st_d.bin  = bin_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gray_o = st_q.gray;
    assign bin_o  = st_q.bin;

    // Checker helpers: shape of the current sample
    int   ones_n;
    logic clean_in;
    always_comb begin
        ones_n   = $countones(cmp_i);
        clean_in = (undec_i == '0) &&
                   (cmp_i == NCMP'((64'(1) << ones_n) - 64'(1)));
    end

    assert_clean_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clean_in |=> (gray_o == OUT_W'(ttg_pkg::gray_of($past(ones_n)))))
        else $error("clean sample gave wrong Gray code");

    assert_bin_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bin_o == OUT_W'(ttg_pkg::bin_of(int'($past(gray_o)), OUT_W))))
        else $error("binary stage does not follow Gray stage");

endmodule

// File: tb/sim_thermo_gray_enc.sv
`timescale 1ns/1ps
module sim_thermo_gray_enc;
    localparam int W = 6;
    localparam int N = 63;
    localparam int NV = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] cmp = '0;
    logic [N-1:0] und = '0;
    logic [W-1:0] gray_o, bin_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    thermo_gray_enc #(.OUT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmp_i(cmp), .undec_i(und),
        .gray_o(gray_o), .bin_o(bin_o)
    );

    // vector table: comparator input, undecided flags, expected Gray code
    localparam logic [N-1:0] V_CMP [NV] = '{
        63'h0, 63'h7FFF_FFFF_FFFF_FFFF, 63'h1, 63'h1F, 63'hFFFF_FFFF,
        63'h3FF_FFFF_FFFF, 63'h21F, 63'h100_000F_FFFF,
        63'h1F, 63'h1F, 63'h0, 63'h37, 63'hCFF };
    localparam logic [N-1:0] V_UND [NV] = '{
        63'h0, 63'h0, 63'h0, 63'h0, 63'h0, 63'h0, 63'h0, 63'h0,
        63'h20, 63'h4000_0000, 63'h7FFF_FFFF_FFFF_FFFF, 63'h0, 63'h0 };
    localparam logic [W-1:0] V_GRAY [NV] = '{
        6'd0, 6'd32, 6'd1, 6'd7, 6'd48, 6'd63, 6'd7, 6'd30,
        6'd5, 6'd7, 6'd32, 6'd7, 6'd14 };
    localparam string V_TAG [NV] = '{
        "R8", "R8", "R2", "R2", "R2", "R2", "R4", "R4",
        "R5", "R5", "R5", "R6", "R6" };

    function automatic logic [W-1:0] to_bin(input logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        // R1: outputs held at zero during reset with active inputs
        cmp = V_CMP[5];
        und = V_UND[10];
        repeat (3) @(negedge clk);
        check("R1 gray", gray_o, '0);
        check("R1 bin", bin_o, '0);
        rst_n = 1'b1;

        // table walk: gray one cycle later, binary one more cycle later (R2, R3)
        for (int v = 0; v < NV; v++) begin
            cmp = V_CMP[v];
            und = V_UND[v];
            @(negedge clk);
            check(V_TAG[v], gray_o, V_GRAY[v]);
            @(negedge clk);
            check("R3", bin_o, to_bin(V_GRAY[v]));
        end

        // R7: back-to-back stream of levels 3, 17, 60
        cmp = 63'h7; und = '0;
        @(negedge clk);
        check("R7 a", gray_o, 6'd2);
        cmp = 63'h1FFFF;
        @(negedge clk);
        check("R7 b", gray_o, 6'd25);
        check("R7 bin a", bin_o, 6'd3);
        cmp = 63'hFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        check("R7 c", gray_o, 6'd34);
        check("R7 bin b", bin_o, 6'd17);
        @(negedge clk);
        check("R7 bin c", bin_o, 6'd60);

        // R8: all ones gives binary 63
        cmp = 63'h7FFF_FFFF_FFFF_FFFF;
        repeat (2) @(negedge clk);
        check("R8 bin", bin_o, 6'd63);

        // R1: reset again clears both stages
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 gray again", gray_o, '0);
        check("R1 bin again", bin_o, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule